// File: doc/BRIEF.md
# Power-Down Mode Control Register

This block holds the control byte that a processor's power-down logic consults whenever the core runs a sleep instruction. Software reaches it through a simple peripheral bus that offers a write strobe, a read strobe and an access-size code. Only byte-wide accesses are honoured.

Three bits are meaningful. The low-power enable is bit 7. The deep select is bit 6. The RTC halt is bit 1. Every other bit is reserved, reads as zero and cannot be written.

The core raises `sleep_exec` when a sleep instruction executes. On the next clock the block emits a one-cycle, one-hot request on one of three outputs: plain sleep, software standby or deep standby. The choice comes from the two mode bits held in the cycle of `sleep_exec`. The RTC halt bit drives the clock enable of a real-time-clock module directly.

The reset sources treat the register differently. A power-on reset clears it, and so does entry into deep standby. A manual reset and entry into software standby leave the contents untouched.

Top module: `pwr_mode_ctl`

## Requirements
- R1: Bit 7 is the low-power enable, bit 6 is the deep select and bit 1 is the RTC halt. While `por_n` is low the register is 0x00 and `rtc_clk_en` is 1.
- R2: A high `deep_entered` at a rising edge clears the register to 0x00 at that edge. This takes priority over a write in the same cycle.
- R3: Asserting `swstby_entered` leaves the register unchanged. Asserting `mrst` also leaves it unchanged. While `mrst` is high, writes are ignored and no mode request is produced.
- R4: A write takes effect only when `acc_size` is 0 (byte). Any other size code leaves the register unchanged.
- R5: When `sleep_exec` is high at a rising edge and `mrst` is low, exactly one request is high for the single following cycle. The request is chosen from bits 7:6 as held before that edge, so a write in the same cycle does not affect it:
  - 00 or 01 gives `sleep_req`;
  - 10 gives `swstby_req`;
  - 11 gives `dpstby_req`.
- R6: `rtc_clk_en` is the inverse of bit 1. After a byte write it follows the new value from the edge that stores it.
- R7: Bits 5 to 2 and bit 0 always read 0, whatever value was written to them.
- R8: `rdata` shows the register combinationally while `rd_en` is high and `acc_size` is 0. Otherwise `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous, clears the register |
| mrst | input | 1 | Manual reset; register retained, writes and requests blocked |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| acc_size | input | 2 | Access size code, 0 = byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| sleep_exec | input | 1 | Pulse: sleep instruction executed |
| deep_entered | input | 1 | Deep standby entered, clears the register |
| swstby_entered | input | 1 | Software standby entered, no effect on contents |
| sleep_req | output | 1 | One-cycle sleep mode request |
| swstby_req | output | 1 | One-cycle software standby request |
| dpstby_req | output | 1 | One-cycle deep standby request |
| rtc_clk_en | output | 1 | Clock enable for the real-time clock |

## Verification
The hardest case to reach is two events at one clock edge. In one, `sleep_exec` coincides with a byte write that changes the mode bits. In the other, `deep_entered` coincides with a write.

The bench drives both events on the same falling edge, so they are captured by the same rising edge. It then checks two things: that the request follows the old mode bits while a later read shows the new ones, and that the clear wins over the write.

Manual-reset blocking is reached the same way. A byte write and a sleep pulse are presented while `mrst` is high, and the bench confirms that nothing moves.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [1:0] {
      PM_NONE   = 2'd0,
      PM_SLEEP  = 2'd1,
      PM_SWSTBY = 2'd2,
      PM_DEEP   = 2'd3
   } pm_mode_e;

   // Mode chosen by the low-power enable and deep select bits.
   function automatic pm_mode_e pm_pick(input logic fire, input logic lp_en, input logic deep_sel);
      if (!fire)
         return PM_NONE;
      else if (!lp_en)
         return PM_SLEEP;
      else if (!deep_sel)
         return PM_SWSTBY;
      else
         return PM_DEEP;
   endfunction

endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg #(
   parameter int REG_W     = 8,
   parameter int LP_BIT    = 7,
   parameter int DEEP_BIT  = 6,
   parameter int RTC_BIT   = 1,
   parameter int SIZE_W    = 2,
   parameter int BYTE_CODE = 0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst,
   input  logic              wr_en,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [REG_W-1:0]  wdata,
   input  logic              deep_entered,
   output logic [REG_W-1:0]  ctl_q
);

   localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'(1) << LP_BIT) | (REG_W'(1) << DEEP_BIT) | (REG_W'(1) << RTC_BIT);

   logic byte_wr;
   assign byte_wr = wr_en && !mrst && (acc_size == SIZE_W'(BYTE_CODE));

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (WR_MASK[b]) begin : g_store
         logic bit_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
               bit_q <= 1'b0;
            else if (deep_entered)
               bit_q <= 1'b0;
            else if (byte_wr)
               bit_q <= wdata[b];
         end
         assign ctl_q[b] = bit_q;
      end else begin : g_rsvd
         assign ctl_q[b] = 1'b0;
      end
   end

endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
   import pwr_mode_pkg::*;
(
   input  logic clk,
   input  logic por_n,
   input  logic mrst,
   input  logic sleep_exec,
   input  logic lp_en,
   input  logic deep_sel,
   output logic sleep_req,
   output logic swstby_req,
   output logic dpstby_req
);

   pm_mode_e pick;
   assign pick = pm_pick(sleep_exec && !mrst, lp_en, deep_sel);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sleep_req  <= 1'b0;
         swstby_req <= 1'b0;
         dpstby_req <= 1'b0;
      end else begin
         sleep_req  <= (pick == PM_SLEEP);
         swstby_req <= (pick == PM_SWSTBY);
         dpstby_req <= (pick == PM_DEEP);
      end
   end

endmodule

// File: rtl/pwr_mode_rdport.sv
module pwr_mode_rdport #(
   parameter int REG_W     = 8,
   parameter int SIZE_W    = 2,
   parameter int BYTE_CODE = 0
) (
   input  logic              rd_en,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [REG_W-1:0]  ctl_q,
   output logic [REG_W-1:0]  rdata
);

   always_comb begin
      if (rd_en && (acc_size == SIZE_W'(BYTE_CODE)))
         rdata = ctl_q;
      else
         rdata = '0;
   end

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
   parameter int REG_W     = 8,
   parameter int LP_BIT    = 7,
   parameter int DEEP_BIT  = 6,
   parameter int RTC_BIT   = 1,
   parameter int SIZE_W    = 2,
   parameter int BYTE_CODE = 0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic              sleep_exec,
   input  logic              deep_entered,
   input  logic              swstby_entered,
   output logic              sleep_req,
   output logic              swstby_req,
   output logic              dpstby_req,
   output logic              rtc_clk_en
);

   if (LP_BIT >= REG_W || DEEP_BIT >= REG_W || RTC_BIT >= REG_W) begin : g_bad_pos
      $error("pwr_mode_ctl: a control bit position lies outside the register");
   end
   if (LP_BIT == DEEP_BIT || LP_BIT == RTC_BIT || DEEP_BIT == RTC_BIT) begin : g_bad_overlap
      $error("pwr_mode_ctl: control bit positions overlap");
   end
   if (BYTE_CODE >= (1 << SIZE_W)) begin : g_bad_size
      $error("pwr_mode_ctl: byte size code does not fit the size field");
   end

   logic [REG_W-1:0] ctl_q;
   logic             swstby_seen;

   // Entry into software standby deliberately does not touch the register.
   assign swstby_seen = swstby_entered;

   pwr_mode_reg #(
      .REG_W(REG_W), .LP_BIT(LP_BIT), .DEEP_BIT(DEEP_BIT), .RTC_BIT(RTC_BIT),
      .SIZE_W(SIZE_W), .BYTE_CODE(BYTE_CODE)
   ) u_reg (
      .clk(clk), .por_n(por_n), .mrst(mrst), .wr_en(wr_en),
      .acc_size(acc_size), .wdata(wdata), .deep_entered(deep_entered),
      .ctl_q(ctl_q)
   );

   pwr_mode_decode u_dec (
      .clk(clk), .por_n(por_n), .mrst(mrst), .sleep_exec(sleep_exec),
      .lp_en(ctl_q[LP_BIT]), .deep_sel(ctl_q[DEEP_BIT]),
      .sleep_req(sleep_req), .swstby_req(swstby_req), .dpstby_req(dpstby_req)
   );

   pwr_mode_rdport #(
      .REG_W(REG_W), .SIZE_W(SIZE_W), .BYTE_CODE(BYTE_CODE)
   ) u_rd (
      .rd_en(rd_en), .acc_size(acc_size), .ctl_q(ctl_q), .rdata(rdata)
   );

   assign rtc_clk_en = !ctl_q[RTC_BIT];

   logic unused_ok;
   assign unused_ok = swstby_seen;

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
   parameter int REG_W     = 8,
   parameter int LP_BIT    = 7,
   parameter int DEEP_BIT  = 6,
   parameter int RTC_BIT   = 1,
   parameter int SIZE_W    = 2,
   parameter int BYTE_CODE = 0
) (
   input logic              clk,
   input logic              por_n,
   input logic              mrst,
   input logic              wr_en,
   input logic              rd_en,
   input logic [SIZE_W-1:0] acc_size,
   input logic [REG_W-1:0]  wdata,
   input logic [REG_W-1:0]  rdata,
   input logic              sleep_exec,
   input logic              deep_entered,
   input logic              sleep_req,
   input logic              swstby_req,
   input logic              dpstby_req,
   input logic              rtc_clk_en,
   input logic [REG_W-1:0]  ctl_q
);

   localparam logic [REG_W-1:0] RSVD =
      ~((REG_W'(1) << LP_BIT) | (REG_W'(1) << DEEP_BIT) | (REG_W'(1) << RTC_BIT));

   logic byte_acc;
   assign byte_acc = (acc_size == SIZE_W'(BYTE_CODE));

   p_deep_clear_r2: assert property (@(posedge clk) disable iff (!por_n)
      deep_entered |=> (ctl_q == '0));

   p_mrst_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
      (mrst && !deep_entered) |=> $stable(ctl_q));

   p_size_guard_r4: assert property (@(posedge clk) disable iff (!por_n)
      (!byte_acc && !deep_entered) |=> $stable(ctl_q));

   p_onehot_r5: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0({sleep_req, swstby_req, dpstby_req}));

   p_sleep_pick_r5: assert property (@(posedge clk) disable iff (!por_n)
      (sleep_exec && !mrst && !ctl_q[LP_BIT]) |=> sleep_req);

   p_one_cycle_r5: assert property (@(posedge clk) disable iff (!por_n)
      (!sleep_exec || mrst) |=> !(sleep_req || swstby_req || dpstby_req));

   p_rtc_follow_r6: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && byte_acc && !mrst && !deep_entered && wdata[RTC_BIT]) |=> !rtc_clk_en);

   p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!por_n)
      ((rdata & RSVD) == '0));

   p_rd_idle_r8: assert property (@(posedge clk) disable iff (!por_n)
      !(rd_en && byte_acc) |-> (rdata == '0));

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(
   .REG_W(REG_W), .LP_BIT(LP_BIT), .DEEP_BIT(DEEP_BIT), .RTC_BIT(RTC_BIT),
   .SIZE_W(SIZE_W), .BYTE_CODE(BYTE_CODE)
) u_chk (
   .clk(clk), .por_n(por_n), .mrst(mrst), .wr_en(wr_en), .rd_en(rd_en),
   .acc_size(acc_size), .wdata(wdata), .rdata(rdata), .sleep_exec(sleep_exec),
   .deep_entered(deep_entered), .sleep_req(sleep_req), .swstby_req(swstby_req),
   .dpstby_req(dpstby_req), .rtc_clk_en(rtc_clk_en), .ctl_q(ctl_q)
);

// File: tb/pwr_mode_ctl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctl_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       mrst = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] acc_size = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       sleep_exec = 1'b0;
   logic       deep_entered = 1'b0;
   logic       swstby_entered = 1'b0;
   logic       sleep_req, swstby_req, dpstby_req, rtc_clk_en;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctl uut (
      .clk(clk), .por_n(por_n), .mrst(mrst), .wr_en(wr_en), .rd_en(rd_en),
      .acc_size(acc_size), .wdata(wdata), .rdata(rdata), .sleep_exec(sleep_exec),
      .deep_entered(deep_entered), .swstby_entered(swstby_entered),
      .sleep_req(sleep_req), .swstby_req(swstby_req), .dpstby_req(dpstby_req),
      .rtc_clk_en(rtc_clk_en)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d, input logic [1:0] sz);
      @(negedge clk);
      wr_en = 1'b1; acc_size = sz; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; acc_size = 2'd0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] exp);
      @(negedge clk);
      rd_en = 1'b1; acc_size = 2'd0;
      #1 check(req, rdata, exp);
      rd_en = 1'b0;
   endtask

   // Pulse sleep_exec, then check the request vector {sleep,sw,deep} and the cycle after.
   task automatic sleep_check(input string req, input logic [2:0] exp);
      @(negedge clk);
      sleep_exec = 1'b1;
      @(negedge clk);
      sleep_exec = 1'b0;
      check(req, {5'd0, sleep_req, swstby_req, dpstby_req}, {5'd0, exp});
      @(negedge clk);
      check({req, " pulse end"}, {5'd0, sleep_req, swstby_req, dpstby_req}, 8'd0);
   endtask

   task automatic t_reset;
      rd_en = 1'b1;
      #1 check("R1 reset rdata", rdata, 8'h00);
      check("R1 reset rtc_clk_en", {7'd0, rtc_clk_en}, 8'h01);
      rd_en = 1'b0;
   endtask

   task automatic t_modes;
      wr(8'h00, 2'd0);
      sleep_check("R5 mode 00 sleep", 3'b100);
      wr(8'h40, 2'd0);
      sleep_check("R5 mode 01 sleep", 3'b100);
      wr(8'h80, 2'd0);
      sleep_check("R5 mode 10 swstby", 3'b010);
      wr(8'hC0, 2'd0);
      sleep_check("R5 mode 11 deep", 3'b001);
      rd_check("R1 bits 7:6 layout", 8'hC0);
   endtask

   task automatic t_same_cycle_write;
      wr(8'h00, 2'd0);
      @(negedge clk);
      sleep_exec = 1'b1; wr_en = 1'b1; wdata = 8'h80; acc_size = 2'd0;
      @(negedge clk);
      sleep_exec = 1'b0; wr_en = 1'b0;
      check("R5 old bits used", {5'd0, sleep_req, swstby_req, dpstby_req}, 8'h04);
      rd_check("R5 write landed", 8'h80);
   endtask

   task automatic t_rtc_rsvd;
      wr(8'hFF, 2'd0);
      rd_check("R7 reserved read zero", 8'hC2);
      check("R6 rtc halted", {7'd0, rtc_clk_en}, 8'h00);
      wr(8'h3D, 2'd0);
      rd_check("R7 only reserved written", 8'h00);
      check("R6 rtc running", {7'd0, rtc_clk_en}, 8'h01);
   endtask

   task automatic t_size;
      wr(8'h82, 2'd0);
      wr(8'h00, 2'd1);
      rd_check("R4 size 1 ignored", 8'h82);
      wr(8'h40, 2'd2);
      wr(8'h00, 2'd3);
      rd_check("R4 sizes 2,3 ignored", 8'h82);
   endtask

   task automatic t_read_gate;
      @(negedge clk);
      rd_en = 1'b0; acc_size = 2'd0;
      #1 check("R8 no strobe", rdata, 8'h00);
      rd_en = 1'b1; acc_size = 2'd2;
      #1 check("R8 non-byte read", rdata, 8'h00);
      acc_size = 2'd0;
      #1 check("R8 byte read", rdata, 8'h82);
      rd_en = 1'b0;
   endtask

   task automatic t_retain;
      wr(8'hC2, 2'd0);
      @(negedge clk);
      swstby_entered = 1'b1;
      @(negedge clk);
      swstby_entered = 1'b0;
      rd_check("R3 swstby retains", 8'hC2);
      @(negedge clk);
      mrst = 1'b1;
      wr(8'h00, 2'd0);
      rd_check("R3 mrst blocks write", 8'hC2);
      @(negedge clk);
      sleep_exec = 1'b1;
      @(negedge clk);
      sleep_exec = 1'b0;
      check("R3 no request in mrst", {5'd0, sleep_req, swstby_req, dpstby_req}, 8'h00);
      mrst = 1'b0;
      rd_check("R3 retained after mrst", 8'hC2);
   endtask

   task automatic t_deep_clear;
      wr(8'hC2, 2'd0);
      @(negedge clk);
      deep_entered = 1'b1;
      @(negedge clk);
      deep_entered = 1'b0;
      rd_check("R2 deep clears", 8'h00);
      wr(8'h82, 2'd0);
      @(negedge clk);
      deep_entered = 1'b1; wr_en = 1'b1; wdata = 8'hC2; acc_size = 2'd0;
      @(negedge clk);
      deep_entered = 1'b0; wr_en = 1'b0;
      rd_check("R2 clear beats write", 8'h00);
   endtask

   task automatic t_por;
      wr(8'hC2, 2'd0);
      @(negedge clk);
      por_n = 1'b0;
      rd_en = 1'b1;
      #1 check("R1 power-on clears", rdata, 8'h00);
      check("R1 rtc enabled in reset", {7'd0, rtc_clk_en}, 8'h01);
      rd_en = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
   endtask

   initial begin
      fork
         begin
            t_reset();
            repeat (2) @(negedge clk);
            por_n = 1'b1;
            t_modes();
            t_same_cycle_write();
            t_rtc_rsvd();
            t_size();
            t_read_gate();
            t_retain();
            t_deep_clear();
            t_por();
         end
         begin
            repeat (5000) @(posedge clk);
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule